// File: doc/BRIEF.md
# PCI Type-0 Configuration Master

This block lets a local processor act as host on a single 32-bit multiplexed PCI bus segment. Through a small local register set it issues one configuration read or write at a time. Repeated single accesses are how the processor walks the bus, probes each slot and programs the devices it finds.

There are three local registers: a configuration address word, a data word and a command/status word. The address word packs three fields:

- a one-hot device-select field in bits 31 to 11, which reaches the target's IDSEL pin through resistive coupling;
- a function number in bits 10 to 8;
- a dword register offset in bits 7 to 2.

The processor loads the data word first when it wants a write. It then writes the command word and waits for the ready flag. Arbitration is done outside the block: the block raises REQ#, waits for GNT# while the bus is idle, and then runs one address phase without stepping, followed by one data phase.

A target may claim the access, ask for a retry or stay silent. If it stays silent, the block ends the cycle as a master abort. Bus-master enable in the block's own configuration header has no bearing on any of this.

Top module: `pcicfg_master`

## Requirements
- R1: After reset: `cfg_ready`=1, `cfg_mabort`=0, `req_n`=`frame_n_o`=`irdy_n_o`=1, and `ad_oe`=`cbe_oe`=`ctl_oe`=0.
- R2: A command write (`reg_sel`=2) made while ready asserts `req_n` from the next cycle. `frame_n_o` falls only in a cycle that follows an edge at which `gnt_n`=0, `bus_frame_n_i`=1 and `bus_irdy_n_i`=1 were sampled.
- R3: The address phase lasts exactly one cycle with `frame_n_o`=0. During it, `ad_o` carries the address register with bits 1:0 forced to 00 (type 0), and `cbe_n_o` is 1010 for a read (command bit 0 = 0) or 1011 for a write (command bit 0 = 1).
- R4: The data phase follows directly with `frame_n_o`=1, `irdy_n_o`=0 and `cbe_n_o`=0000. A write drives the data register on `ad_o` with `ad_oe`=1; a read keeps `ad_oe`=0.
- R5: The data phase ends at the first edge where `devsel_n` has been seen low (at this edge or an earlier one) and `trdy_n`=0. A read stores `ad_i` of that edge in the data register. `cfg_ready` reads 1 two cycles after that edge, with `cfg_mabort`=0.
- R6: If `devsel_n` is not sampled low at any of the first 5 data-phase edges, the access ends after 5 data cycles. `cfg_mabort` is then 1, a read leaves FFFFFFFF in the data register, and `cfg_ready` still rises.
- R7: When `devsel_n`=0, `stop_n`=0 and `trdy_n`=1 at a data-phase edge, the attempt ends and the block requests the bus again. It then repeats the same access until it completes.
- R8: A command issued while the device-select field (bits 31:11) is not one-hot produces no bus activity: `req_n` stays 1. The command completes at once with `cfg_ready`=1 and `cfg_mabort`=1, and a read stores FFFFFFFF.
- R9: While `cfg_ready`=0, writes to the address, data and command registers are ignored.
- R10: `reg_rdata` returns the address register (bits 1:0 read 0) for select 0, the data register for select 1, and {30'b0, mabort, ready} for select 2. A newly accepted command clears mabort.
- R11: Each data phase is followed by exactly one turnaround cycle in which `ctl_oe`=1 with `frame_n_o`=`irdy_n_o`=1. After it, `ctl_oe`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | PCI clock |
| rst_n | input | 1 | synchronous active-low reset |
| reg_wr | input | 1 | local register write strobe |
| reg_sel | input | 2 | local register select: 0 address, 1 data, 2 command/status |
| reg_wdata | input | 32 | local write data |
| reg_rdata | output | 32 | local read data for `reg_sel` |
| cfg_ready | output | 1 | no access pending; last access finished |
| cfg_mabort | output | 1 | last access ended in master abort |
| req_n | output | 1 | bus request to the external arbiter |
| gnt_n | input | 1 | bus grant from the external arbiter |
| bus_frame_n_i | input | 1 | FRAME# as seen on the bus |
| bus_irdy_n_i | input | 1 | IRDY# as seen on the bus |
| devsel_n | input | 1 | target device select |
| trdy_n | input | 1 | target ready |
| stop_n | input | 1 | target stop |
| ad_i | input | 32 | AD as seen on the bus |
| ad_o | output | 32 | AD drive value |
| ad_oe | output | 1 | AD output enable |
| cbe_n_o | output | 4 | C/BE# drive value |
| cbe_oe | output | 1 | C/BE# output enable |
| frame_n_o | output | 1 | FRAME# drive value |
| irdy_n_o | output | 1 | IRDY# drive value |
| ctl_oe | output | 1 | FRAME#/IRDY# output enable |

## Verification
The hardest state to reach is a retry followed by a master abort window. The attempt counter and the devsel timer must restart cleanly on the second attempt, and this only happens when a target answers one attempt with STOP# and is then handled differently on the next. The bench reaches it with a cycle-level target model. The model asserts DEVSEL#, TRDY# or STOP# a programmed number of data cycles after each address phase, and it holds a count of retries to give before it accepts the access. A sweep over devsel latency, ready latency, grant latency and direction then places DEVSEL# on every edge of the abort window, including the last edge that still counts and the first edge that no longer does.

// File: rtl/pcicfg_pkg.sv
// Shared constants and types for the configuration master.
// Assumes a 32-bit multiplexed bus and 4-bit byte enables.
package pcicfg_pkg;
    // local register selects
    localparam logic [1:0] REG_ADDR = 2'd0;
    localparam logic [1:0] REG_DATA = 2'd1;
    localparam logic [1:0] REG_CTRL = 2'd2;

    // bus command codes driven on C/BE# during the address phase
    localparam logic [3:0] CBE_CFG_RD = 4'b1010;
    localparam logic [3:0] CBE_CFG_WR = 4'b1011;
    localparam logic [3:0] CBE_ALL_ON = 4'b0000;
    localparam logic [3:0] CBE_IDLE   = 4'b1111;

    typedef enum logic [2:0] {
        SQ_IDLE,
        SQ_REQ,
        SQ_ADDR,
        SQ_DATA,
        SQ_TURN
    } seq_state_e;

    typedef enum logic [1:0] {
        END_NONE,
        END_OK,
        END_ABORT,
        END_RETRY
    } end_kind_e;
endpackage

// File: rtl/pcicfg_sel_check.sv
// Device-select field checker: reports whether exactly one bit of the
// select field is set. Purely combinational; assumes FW >= 1.
module pcicfg_sel_check #(
    parameter int FW = 21
) (
    input  logic [FW-1:0] sel_field,
    output logic          sel_ok
);
    localparam int CNTW = $clog2(FW + 1);

    logic [CNTW-1:0] ones;

    // population count of the select field
    always_comb begin
        ones = '0;
        for (int i = 0; i < FW; i++) begin
            ones = ones + CNTW'(sel_field[i]);
        end
    end

    // one-hot test
    assign sel_ok = (ones == CNTW'(1));
endmodule

// File: rtl/pcicfg_regs.sv
// Local register set: address word, data word and command/status.
// Accepts writes only while ready; a command with a bad device select is
// finished locally as a master abort. Assumes done arrives only while busy.
module pcicfg_regs
    import pcicfg_pkg::*;
#(
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [1:0]    sel,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] rdata,
    input  logic          sel_ok,
    input  logic          done,
    input  logic          done_abort,
    input  logic [DW-1:0] done_rdata,
    output logic [DW-1:2] cfg_addr,
    output logic [DW-1:0] cfg_data,
    output logic          cmd_write,
    output logic          start,
    output logic          ready,
    output logic          mabort
);
    logic cmd_acc;

    // a command write is accepted only while idle
    assign cmd_acc = wr_en && ready && (sel == REG_CTRL);
    assign start   = cmd_acc && sel_ok;

    // register updates from local writes and bus completions
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_addr  <= '0;
            cfg_data  <= '0;
            cmd_write <= 1'b0;
            ready     <= 1'b1;
            mabort    <= 1'b0;
        end else if (wr_en && ready) begin
            case (sel)
                REG_ADDR: cfg_addr <= wdata[DW-1:2];
                REG_DATA: cfg_data <= wdata;
                REG_CTRL: begin
                    cmd_write <= wdata[0];
                    mabort    <= !sel_ok;
                    if (sel_ok) begin
                        ready <= 1'b0;
                    end else if (!wdata[0]) begin
                        cfg_data <= '1;
                    end
                end
                default: ;
            endcase
        end else if (done) begin
            ready  <= 1'b1;
            mabort <= done_abort;
            if (!cmd_write) begin
                cfg_data <= done_abort ? '1 : done_rdata;
            end
        end
    end

    // local read mux
    always_comb begin
        case (sel)
            REG_ADDR: rdata = {cfg_addr, 2'b00};
            REG_DATA: rdata = cfg_data;
            REG_CTRL: rdata = {{(DW-2){1'b0}}, mabort, ready};
            default:  rdata = '0;
        endcase
    end

    // R9
    busy_addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!ready && wr_en && sel == REG_ADDR) |=> cfg_addr == $past(cfg_addr));

    // R9
    busy_data_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!ready && !done && wr_en && sel == REG_DATA) |=> cfg_data == $past(cfg_data));

    // R8
    bad_sel_abort_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_acc && !sel_ok) |=> (ready && mabort));

    // R10
    start_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> (!ready && !mabort));
endmodule

// File: rtl/pcicfg_bus_seq.sv
// Bus sequencer: request, single address phase, single data phase and
// turnaround. Handles target completion, retry and master abort.
// Assumes the arbiter parks nothing on the bus while GNT# is ours.
module pcicfg_bus_seq
    import pcicfg_pkg::*;
#(
    parameter int DW         = 32,
    parameter int ABORT_CLKS = 5
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic          is_write,
    input  logic [DW-1:2] cfg_addr,
    input  logic [DW-1:0] cfg_data,
    input  logic          gnt_n,
    input  logic          bus_frame_n_i,
    input  logic          bus_irdy_n_i,
    input  logic          devsel_n,
    input  logic          trdy_n,
    input  logic          stop_n,
    input  logic [DW-1:0] ad_i,
    output logic          req_n,
    output logic          frame_n_o,
    output logic          irdy_n_o,
    output logic [3:0]    cbe_n_o,
    output logic          cbe_oe,
    output logic [DW-1:0] ad_o,
    output logic          ad_oe,
    output logic          ctl_oe,
    output logic          done,
    output logic          done_abort,
    output logic [DW-1:0] done_rdata
);
    localparam int             CW        = $clog2(ABORT_CLKS + 1);
    localparam logic [CW-1:0]  LAST_WAIT = CW'(ABORT_CLKS - 1);

    seq_state_e     state;
    end_kind_e      end_kind;
    logic           dev_seen;
    logic           dev_hit;
    logic           bus_free;
    logic [CW-1:0]  wait_cnt;
    logic [DW-1:0]  rd_word;

    assign dev_hit  = dev_seen || !devsel_n;
    assign bus_free = !gnt_n && bus_frame_n_i && bus_irdy_n_i;

    // transaction sequencing
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= SQ_IDLE;
            end_kind <= END_NONE;
            dev_seen <= 1'b0;
            wait_cnt <= '0;
        end else begin
            case (state)
                SQ_IDLE: if (start) state <= SQ_REQ;
                SQ_REQ:  if (bus_free) state <= SQ_ADDR;
                SQ_ADDR: begin
                    state    <= SQ_DATA;
                    dev_seen <= 1'b0;
                    wait_cnt <= '0;
                end
                SQ_DATA: begin
                    if (dev_hit && !trdy_n) begin
                        end_kind <= END_OK;
                        state    <= SQ_TURN;
                    end else if (dev_hit && !stop_n) begin
                        end_kind <= END_RETRY;
                        state    <= SQ_TURN;
                    end else if (!dev_hit && wait_cnt == LAST_WAIT) begin
                        end_kind <= END_ABORT;
                        state    <= SQ_TURN;
                    end else begin
                        dev_seen <= dev_hit;
                        if (!dev_hit) wait_cnt <= wait_cnt + 1'b1;
                    end
                end
                SQ_TURN: state <= (end_kind == END_RETRY) ? SQ_REQ : SQ_IDLE;
                default: state <= SQ_IDLE;
            endcase
        end
    end

    // capture of the read word on target completion
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_word <= '0;
        end else if (state == SQ_DATA && dev_hit && !trdy_n) begin
            rd_word <= ad_i;
        end
    end

    // bus drive values decoded from the state
    always_comb begin
        req_n     = (state != SQ_REQ);
        frame_n_o = (state != SQ_ADDR);
        irdy_n_o  = (state != SQ_DATA);
        ctl_oe    = (state == SQ_ADDR) || (state == SQ_DATA) || (state == SQ_TURN);
        cbe_oe    = (state == SQ_ADDR) || (state == SQ_DATA);
        ad_oe     = (state == SQ_ADDR) || (state == SQ_DATA && is_write);
        cbe_n_o   = CBE_IDLE;
        ad_o      = '0;
        if (state == SQ_ADDR) begin
            cbe_n_o = is_write ? CBE_CFG_WR : CBE_CFG_RD;
            ad_o    = {cfg_addr, 2'b00};
        end else if (state == SQ_DATA) begin
            cbe_n_o = CBE_ALL_ON;
            if (is_write) ad_o = cfg_data;
        end
    end

    // completion report to the register set
    assign done       = (state == SQ_TURN) && (end_kind != END_RETRY);
    assign done_abort = (end_kind == END_ABORT);
    assign done_rdata = rd_word;

    // run length of data cycles without a claim, kept for checking
    logic [CW:0] nodev_run;
    always_ff @(posedge clk) begin
        if (!rst_n) nodev_run <= '0;
        else if (state == SQ_DATA && !dev_hit) nodev_run <= nodev_run + 1'b1;
        else if (state != SQ_DATA) nodev_run <= '0;
    end

    // R6
    nodev_limit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        nodev_run <= (CW+1)'(ABORT_CLKS));

    // R2
    frame_after_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !frame_n_o |-> $past(!gnt_n && bus_frame_n_i && bus_irdy_n_i));

    // R3
    single_addr_phase_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !frame_n_o |=> (frame_n_o && !irdy_n_o));

    // R4
    data_phase_shape_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !irdy_n_o |-> (frame_n_o && cbe_oe && cbe_n_o == 4'b0000));

    // R5
    target_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!irdy_n_o && !devsel_n && !trdy_n) |=> irdy_n_o);

    // R11
    turnaround_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irdy_n_o) |-> (ctl_oe && frame_n_o));
endmodule

// File: rtl/pcicfg_master.sv
// Configuration master top: local register set, device-select checker
// and bus sequencer. Assumes external arbitration and a single segment.
module pcicfg_master
    import pcicfg_pkg::*;
#(
    parameter int DW         = 32,
    parameter int SEL_LSB    = 11,
    parameter int ABORT_CLKS = 5
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          reg_wr,
    input  logic [1:0]    reg_sel,
    input  logic [DW-1:0] reg_wdata,
    output logic [DW-1:0] reg_rdata,
    output logic          cfg_ready,
    output logic          cfg_mabort,
    output logic          req_n,
    input  logic          gnt_n,
    input  logic          bus_frame_n_i,
    input  logic          bus_irdy_n_i,
    input  logic          devsel_n,
    input  logic          trdy_n,
    input  logic          stop_n,
    input  logic [DW-1:0] ad_i,
    output logic [DW-1:0] ad_o,
    output logic          ad_oe,
    output logic [3:0]    cbe_n_o,
    output logic          cbe_oe,
    output logic          frame_n_o,
    output logic          irdy_n_o,
    output logic          ctl_oe
);
    localparam int FW = DW - SEL_LSB;

    logic [DW-1:2] cfg_addr;
    logic [DW-1:0] cfg_data;
    logic [DW-1:0] done_rdata;
    logic          cmd_write, start, sel_ok, done, done_abort;

    pcicfg_sel_check #(.FW(FW)) u_sel (
        .sel_field (cfg_addr[DW-1:SEL_LSB]),
        .sel_ok    (sel_ok)
    );

    pcicfg_regs #(.DW(DW)) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (reg_wr),
        .sel        (reg_sel),
        .wdata      (reg_wdata),
        .rdata      (reg_rdata),
        .sel_ok     (sel_ok),
        .done       (done),
        .done_abort (done_abort),
        .done_rdata (done_rdata),
        .cfg_addr   (cfg_addr),
        .cfg_data   (cfg_data),
        .cmd_write  (cmd_write),
        .start      (start),
        .ready      (cfg_ready),
        .mabort     (cfg_mabort)
    );

    pcicfg_bus_seq #(.DW(DW), .ABORT_CLKS(ABORT_CLKS)) u_seq (
        .clk           (clk),
        .rst_n         (rst_n),
        .start         (start),
        .is_write      (cmd_write),
        .cfg_addr      (cfg_addr),
        .cfg_data      (cfg_data),
        .gnt_n         (gnt_n),
        .bus_frame_n_i (bus_frame_n_i),
        .bus_irdy_n_i  (bus_irdy_n_i),
        .devsel_n      (devsel_n),
        .trdy_n        (trdy_n),
        .stop_n        (stop_n),
        .ad_i          (ad_i),
        .req_n         (req_n),
        .frame_n_o     (frame_n_o),
        .irdy_n_o      (irdy_n_o),
        .cbe_n_o       (cbe_n_o),
        .cbe_oe        (cbe_oe),
        .ad_o          (ad_o),
        .ad_oe         (ad_oe),
        .ctl_oe        (ctl_oe),
        .done          (done),
        .done_abort    (done_abort),
        .done_rdata    (done_rdata)
    );

    // R1
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_ready |-> (req_n && frame_n_o && irdy_n_o && !ad_oe));
endmodule

// File: tb/tb_pcicfg_master.sv
module tb_pcicfg_master;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [1:0]  reg_sel = 2'd0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        cfg_ready, cfg_mabort, req_n;
    logic        gnt_n = 1'b1, bus_frame_n_i = 1'b1, bus_irdy_n_i = 1'b1;
    logic        devsel_n = 1'b1, trdy_n = 1'b1, stop_n = 1'b1;
    logic [31:0] ad_i = '0;
    logic [31:0] ad_o;
    logic        ad_oe, cbe_oe, frame_n_o, irdy_n_o, ctl_oe;
    logic [3:0]  cbe_n_o;

    always #4 clk = ~clk;

    pcicfg_master dut (.*);

    int n_chk = 0, n_fail = 0;

    // model knobs and observations
    int dev_lat = 1, trdy_lat = 0, gnt_lat = 0, retries = 0, busy_left = 0;
    bit absent = 0;
    logic [31:0] rd_val = '0;
    int gnt_cnt = 0, dcnt = 0, addr_phases = 0, irdy_cycles = 0, turn_cycles = 0;
    int req_lows = 0, frame_viol = 0;
    bit last_busy = 0, rd_oe_seen = 0;
    logic [31:0] addr_seen = '0, data_seen = '0;
    logic [3:0]  cbe_addr = '0, cbe_data = '0;

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // arbiter, bus-busy and target model, all driven away from the clock edge
    always @(negedge clk) begin
        if (!rst_n) begin
            gnt_n = 1; devsel_n = 1; trdy_n = 1; stop_n = 1;
        end else begin
            if (!req_n) begin
                req_lows++;
                gnt_cnt++;
                gnt_n = (gnt_cnt > gnt_lat) ? 1'b0 : 1'b1;
            end else begin
                gnt_cnt = 0; gnt_n = 1;
            end
            if (!frame_n_o && last_busy) frame_viol++;
            bus_frame_n_i = (busy_left == 0);
            if (busy_left > 0) busy_left--;
            last_busy = !bus_frame_n_i;
            if (!frame_n_o) begin
                addr_phases++; addr_seen = ad_o; cbe_addr = cbe_n_o; dcnt = 0;
                devsel_n = 1; trdy_n = 1; stop_n = 1;
            end else if (!irdy_n_o) begin
                dcnt++; irdy_cycles++; cbe_data = cbe_n_o; data_seen = ad_o;
                if (ad_oe) rd_oe_seen = 1;
                if (!absent) begin
                    if (dcnt >= dev_lat) devsel_n = 0;
                    if (dcnt >= dev_lat + trdy_lat) begin
                        if (retries > 0) stop_n = 0;
                        else begin trdy_n = 0; ad_i = rd_val; end
                    end
                end
            end else begin
                if (ctl_oe) turn_cycles++;
                if (!stop_n) retries--;
                devsel_n = 1; trdy_n = 1; stop_n = 1;
            end
        end
    end

    task automatic reg_write(input logic [1:0] s, input logic [31:0] v);
        @(negedge clk);
        reg_wr = 1; reg_sel = s; reg_wdata = v;
        @(negedge clk);
        reg_wr = 0;
    endtask

    task automatic reg_read(input logic [1:0] s, output logic [31:0] v);
        reg_sel = s;
        #1;
        v = reg_rdata;
    endtask

    task automatic clear_obs();
        addr_phases = 0; irdy_cycles = 0; turn_cycles = 0; req_lows = 0;
        rd_oe_seen = 0; frame_viol = 0;
    endtask

    // issues one command and returns the number of negedges until ready
    task automatic run_cmd(input bit wr, input logic [31:0] addr, input logic [31:0] wd,
                           output int lat);
        reg_write(2'd0, addr);
        if (wr) reg_write(2'd1, wd);
        clear_obs();
        reg_write(2'd2, {31'b0, wr});
        lat = 1;
        while (!cfg_ready && lat < 200) begin
            @(negedge clk);
            lat++;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual hung expected finished");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        logic [31:0] v, a, exp_addr;
        int lat, idx;
        repeat (3) @(negedge clk);
        // R1 reset state
        check("R1 ready", {31'b0, cfg_ready}, 1);
        check("R1 mabort", {31'b0, cfg_mabort}, 0);
        check("R1 bus idle", {28'b0, req_n, frame_n_o, irdy_n_o, ctl_oe}, 32'b1110);
        check("R1 enables", {30'b0, ad_oe, cbe_oe}, 0);
        rst_n = 1;
        @(negedge clk);

        // R2 R3 R4 R5 R11: sweep of direction, claim, ready and grant latency
        idx = 0;
        for (int w = 0; w < 2; w++)
            for (int d = 1; d <= 5; d++)
                for (int t = 0; t < 3; t++)
                    for (int g = 0; g < 2; g++) begin
                        dev_lat = d; trdy_lat = t; gnt_lat = g; absent = 0; retries = 0;
                        a = (32'h1 << (11 + idx % 21)) | ((idx % 8) << 8) | ((idx * 4) & 8'hFC) | 2'b11;
                        exp_addr = a & 32'hFFFF_FFFC;
                        rd_val = 32'hA5C3_0000 + idx;
                        run_cmd(w[0], a, 32'h5A00_0000 + idx, lat);
                        check("R3 addr word", addr_seen, exp_addr);
                        check("R3 command code", {28'b0, cbe_addr}, w ? 32'hB : 32'hA);
                        check("R4 data enables", {28'b0, cbe_data}, 0);
                        check("R5 data cycles", irdy_cycles, d + t);
                        check("R5 ready latency", lat, g + d + t + 4);
                        check("R5 mabort", {31'b0, cfg_mabort}, 0);
                        check("R11 turnaround", turn_cycles, 1);
                        if (w) begin
                            check("R4 write data", data_seen, 32'h5A00_0000 + idx);
                        end else begin
                            check("R4 read no drive", {31'b0, rd_oe_seen}, 0);
                            reg_read(2'd1, v);
                            check("R5 read data", v, rd_val);
                        end
                        idx++;
                    end

        // R6 master abort: silent target and a claim one edge too late
        for (int w = 0; w < 2; w++)
            for (int late = 0; late < 2; late++) begin
                absent = (late == 0); dev_lat = 6; trdy_lat = 0; gnt_lat = 0; retries = 0;
                run_cmd(w[0], 32'h0000_0800, 32'h1234_5678, lat);
                check("R6 data cycles", irdy_cycles, 5);
                check("R6 mabort", {31'b0, cfg_mabort}, 1);
                check("R6 ready", {31'b0, cfg_ready}, 1);
                if (!w) begin
                    reg_read(2'd1, v);
                    check("R6 read all ones", v, 32'hFFFF_FFFF);
                end
            end
        absent = 0;

        // R7 retries followed by completion
        for (int r = 1; r <= 2; r++) begin
            dev_lat = 1; trdy_lat = 0; gnt_lat = 0; retries = r; rd_val = 32'hC0DE_0000 + r;
            run_cmd(1'b0, 32'h0010_0304, 0, lat);
            check("R7 attempts", addr_phases, r + 1);
            check("R7 data cycles", irdy_cycles, r + 1);
            check("R11 turnaround per attempt", turn_cycles, r + 1);
            reg_read(2'd1, v);
            check("R7 read data", v, rd_val);
            check("R7 mabort", {31'b0, cfg_mabort}, 0);
        end

        // R2 bus busy holds off the address phase
        dev_lat = 1; gnt_lat = 0; busy_left = 4;
        run_cmd(1'b0, 32'h8000_0000, 0, lat);
        check("R2 no frame while busy", frame_viol, 0);
        check("R2 single address phase", addr_phases, 1);
        check("R2 request seen", {31'b0, req_lows > 0}, 1);

        // R8 invalid device select: none, two bits, only low bits
        for (int k = 0; k < 3; k++) begin
            a = (k == 0) ? 32'h0 : (k == 1) ? 32'h0000_1800 : 32'h0000_07FC;
            run_cmd(1'b0, a, 0, lat);
            repeat (3) @(negedge clk);
            check("R8 no request", req_lows, 0);
            check("R8 no address phase", addr_phases, 0);
            check("R8 status", {30'b0, cfg_mabort, cfg_ready}, 32'b11);
            reg_read(2'd1, v);
            check("R8 read all ones", v, 32'hFFFF_FFFF);
        end

        // R10 readback and mabort clear on a new command
        dev_lat = 1; rd_val = 32'h0BAD_F00D;
        run_cmd(1'b0, 32'h0040_0123, 0, lat);
        reg_read(2'd0, v);
        check("R10 address readback", v, 32'h0040_0120);
        reg_read(2'd2, v);
        check("R10 status word", v, 32'b01);

        // R9 writes while busy are ignored
        gnt_lat = 3; dev_lat = 2;
        reg_write(2'd0, 32'h0000_0810);
        reg_write(2'd1, 32'h1111_2222);
        clear_obs();
        reg_write(2'd2, 32'h1);
        reg_write(2'd0, 32'h0200_0000);
        reg_write(2'd1, 32'h3333_4444);
        reg_write(2'd2, 32'h0);
        while (!cfg_ready) @(negedge clk);
        repeat (8) @(negedge clk);
        check("R9 address kept", addr_seen, 32'h0000_0810);
        check("R9 data kept", data_seen, 32'h1111_2222);
        check("R9 command ignored", addr_phases, 1);
        reg_read(2'd0, v);
        check("R9 address register", v, 32'h0000_0810);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule